// File: doc/BRIEF.md
# Multi-queue priority transmit scheduler

This block picks the next transmit descriptor to send from a set of circular transmit queues and tags it with the output FIFO channel that must carry it. Every queue has its own settings: an enable bit, the channel it feeds, a delivery mode, a window size and a frame limit. Several queues may feed one channel. Each cycle the block offers at most one descriptor on a shared valid/ready output. The offer names the queue, the channel and the descriptor index inside that queue's ring.

A queue runs in one of two modes. In strict mode it sends one descriptor at a time. It waits for that descriptor's completion, resends it on a negative completion, and gives up after a fixed number of attempts. In windowed mode it streams consecutive descriptors up to a bounded number in flight. Positive completions retire the oldest descriptor. A negative completion rewinds the queue to its oldest unacknowledged descriptor. One designated control queue always runs in strict mode. The host supplies each queue's write pointer, and the block keeps and exports each read pointer.

Channels are ranked by index, and the highest-numbered channel that has a ready queue gets the output. Queues that share a channel take turns.

Top module: `txq_scheduler`

## Requirements
- R1: After reset `iss_valid` is low and every read pointer in `rd_ptr` is zero.
- R2: A queue is offered only when its enable bit is set, the descriptor it would send is not at its write pointer, and its channel field names an existing channel (value below NUM_CH). A disabled queue, or a queue with an out-of-range channel, never issues and keeps its read pointer.
- R3: A strict-mode queue offers the descriptor at its read pointer. Once that descriptor is accepted, the queue offers nothing until a completion for it arrives. A positive completion advances the read pointer by one, modulo DEPTH.
- R4: On a negative completion, a strict-mode queue offers the same descriptor again. The RETRY_LIMIT-th consecutive negative completion retires the descriptor: the read pointer advances and the attempt count clears.
- R5: A windowed queue (mode bit 1) offers consecutive descriptors while the number in flight (send index minus read pointer, modulo DEPTH) is below both its window size and its frame limit. Each positive completion retires the oldest descriptor.
- R6: A negative completion on a windowed queue rewinds its send index to the read pointer, so the oldest unacknowledged descriptor is offered next. The rewind overrides an acceptance from that queue in the same cycle.
- R7: Queues sharing a channel are served round-robin. After queue q is accepted, that channel next offers the first ready queue above q in cyclic index order. After reset the search starts at queue 0.
- R8: When several channels have a ready queue, the highest-numbered channel is offered.
- R9: A descriptor counts as sent only in a cycle where `iss_valid` and `iss_ready` are both high. While `iss_ready` is low and no completion arrives, the offer and all pointers stay unchanged.
- R10: Queue CMD_QUEUE runs in strict mode whatever its mode bit says.
- R11: A completion addressed to a queue with nothing in flight changes no state.
- R12: `iss_chan` always equals the channel field of the queue named by `iss_queue`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_active | input | NUM_Q | Per-queue enable |
| cfg_windowed | input | NUM_Q | Per-queue mode: 1 windowed, 0 strict |
| cfg_chan | input | NUM_Q*CH_W | Per-queue target channel, queue q at bits [q*CH_W +: CH_W] |
| cfg_win | input | NUM_Q*7 | Per-queue window size |
| cfg_flim | input | NUM_Q*7 | Per-queue frame limit |
| wr_ptr | input | NUM_Q*PTR_W | Per-queue write pointer from the host |
| iss_valid | output | 1 | A descriptor is offered |
| iss_ready | input | 1 | The output accepts the offer |
| iss_queue | output | Q_W | Queue of the offered descriptor |
| iss_chan | output | CH_W | Channel of the offered descriptor |
| iss_desc | output | PTR_W | Descriptor index within the queue ring |
| cmp_valid | input | 1 | Completion report strobe |
| cmp_queue | input | Q_W | Queue the completion belongs to |
| cmp_ack | input | 1 | 1 positive completion, 0 negative |
| rd_ptr | output | NUM_Q*PTR_W | Per-queue read pointer |

## Verification
Several properties are checked on every cycle. The offered channel must match its queue's field. Only enabled queues are offered, and never at their write pointer. Strict-mode and control-queue offers come from the head of the ring. Windowed offers stay inside both bounds. Read pointers only ever step forward by one. Round-robin order, channel precedence, retry exhaustion, rewind after a negative completion, stall behaviour and pointer wrap are covered only by the bench, which runs a behavioural model of every queue alongside the design and compares the offer and all read pointers on each cycle.

// File: rtl/txq_sched_pkg.sv
package txq_sched_pkg;

   localparam int WIN_W = 7;

   typedef enum logic {
      MODE_STRICT   = 1'b0,
      MODE_WINDOWED = 1'b1
   } txq_mode_e;

endpackage

// File: rtl/txq_queue_ctx.sv
module txq_queue_ctx
   import txq_sched_pkg::*;
#(
   parameter int DEPTH         = 256,
   parameter int RETRY_LIMIT   = 4,
   parameter bit FORCE_STRICT  = 1'b0,
   localparam int PTR_W        = $clog2(DEPTH),
   localparam int RT_W         = $clog2(RETRY_LIMIT),
   localparam int CW           = (PTR_W > WIN_W) ? PTR_W : WIN_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_active,
   input  logic             cfg_windowed,
   input  logic [WIN_W-1:0] cfg_win,
   input  logic [WIN_W-1:0] cfg_flim,
   input  logic [PTR_W-1:0] wr_ptr,
   input  logic             grant,
   input  logic             cmp_hit,
   input  logic             cmp_ack,
   output logic             ready,
   output logic [PTR_W-1:0] desc,
   output logic [PTR_W-1:0] rd_ptr
);

   txq_mode_e        mode;
   logic [PTR_W-1:0] rd_q;
   logic [PTR_W-1:0] snd_q;
   logic             busy_q;
   logic [RT_W-1:0]  tries_q;
   logic [PTR_W-1:0] inflight;
   logic [CW-1:0]    inflight_w;
   logic             below_win;
   logic             below_flim;
   logic             retire_strict;

   assign mode       = (cfg_windowed && !FORCE_STRICT) ? MODE_WINDOWED : MODE_STRICT;
   assign inflight   = snd_q - rd_q;
   assign inflight_w = CW'(inflight);
   assign below_win  = inflight_w < CW'(cfg_win);
   assign below_flim = inflight_w < CW'(cfg_flim);
   assign rd_ptr     = rd_q;

   assign retire_strict = cmp_hit && busy_q &&
                          (cmp_ack || (tries_q == RT_W'(RETRY_LIMIT - 1)));

   always_comb begin
      if (mode == MODE_STRICT) begin
         ready = cfg_active && !busy_q && (rd_q != wr_ptr);
         desc  = rd_q;
      end else begin
         ready = cfg_active && (snd_q != wr_ptr) && below_win && below_flim;
         desc  = snd_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q    <= '0;
         snd_q   <= '0;
         busy_q  <= 1'b0;
         tries_q <= '0;
      end else if (mode == MODE_STRICT) begin
         if (cmp_hit && busy_q) begin
            busy_q <= 1'b0;
            if (retire_strict) begin
               rd_q    <= rd_q + PTR_W'(1);
               snd_q   <= rd_q + PTR_W'(1);
               tries_q <= '0;
            end else begin
               snd_q   <= rd_q;
               tries_q <= tries_q + RT_W'(1);
            end
         end else begin
            snd_q <= rd_q;
            if (grant) begin
               busy_q <= 1'b1;
            end
         end
      end else begin
         busy_q  <= 1'b0;
         tries_q <= '0;
         if (cmp_hit && (inflight != '0)) begin
            if (cmp_ack) begin
               rd_q <= rd_q + PTR_W'(1);
               if (grant) begin
                  snd_q <= snd_q + PTR_W'(1);
               end
            end else begin
               snd_q <= rd_q;
            end
         end else if (grant) begin
            snd_q <= snd_q + PTR_W'(1);
         end
      end
   end

endmodule

// File: rtl/txq_chan_rr.sv
module txq_chan_rr #(
   parameter int NUM_Q = 16,
   localparam int Q_W  = $clog2(NUM_Q)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NUM_Q-1:0] req,
   input  logic             advance,
   output logic             any,
   output logic [Q_W-1:0]   sel
);

   logic [Q_W-1:0] last_q;

   always_comb begin
      any = 1'b0;
      sel = '0;
      for (int off = 1; off <= NUM_Q; off++) begin
         int idx;
         idx = (int'(last_q) + off) % NUM_Q;
         if (!any && req[idx]) begin
            any = 1'b1;
            sel = Q_W'(idx);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_q <= Q_W'(NUM_Q - 1);
      end else if (advance) begin
         last_q <= sel;
      end
   end

endmodule

// File: rtl/txq_chan_prio.sv
module txq_chan_prio #(
   parameter int NUM_Q  = 16,
   parameter int NUM_CH = 7,
   localparam int Q_W   = $clog2(NUM_Q),
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH + 1) : 1
) (
   input  logic [NUM_CH-1:0]     ch_any,
   input  logic [NUM_CH*Q_W-1:0] ch_sel,
   output logic                  valid,
   output logic [CH_W-1:0]       chan,
   output logic [Q_W-1:0]        queue
);

   always_comb begin
      valid = 1'b0;
      chan  = '0;
      queue = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (ch_any[c]) begin
            valid = 1'b1;
            chan  = CH_W'(c);
            queue = ch_sel[c*Q_W +: Q_W];
         end
      end
   end

endmodule

// File: rtl/txq_scheduler.sv
module txq_scheduler
   import txq_sched_pkg::*;
#(
   parameter int NUM_Q       = 16,
   parameter int NUM_CH      = 7,
   parameter int DEPTH       = 256,
   parameter int RETRY_LIMIT = 4,
   parameter int CMD_QUEUE   = 4,
   localparam int Q_W        = $clog2(NUM_Q),
   localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH + 1) : 1,
   localparam int PTR_W      = $clog2(DEPTH)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_Q-1:0]       cfg_active,
   input  logic [NUM_Q-1:0]       cfg_windowed,
   input  logic [NUM_Q*CH_W-1:0]  cfg_chan,
   input  logic [NUM_Q*WIN_W-1:0] cfg_win,
   input  logic [NUM_Q*WIN_W-1:0] cfg_flim,
   input  logic [NUM_Q*PTR_W-1:0] wr_ptr,
   output logic                   iss_valid,
   input  logic                   iss_ready,
   output logic [Q_W-1:0]         iss_queue,
   output logic [CH_W-1:0]        iss_chan,
   output logic [PTR_W-1:0]       iss_desc,
   input  logic                   cmp_valid,
   input  logic [Q_W-1:0]         cmp_queue,
   input  logic                   cmp_ack,
   output logic [NUM_Q*PTR_W-1:0] rd_ptr
);

   if (NUM_Q < 2) begin : g_bad_nq
      $error("txq_scheduler: NUM_Q must be at least 2");
   end
   if (NUM_CH < 1) begin : g_bad_nch
      $error("txq_scheduler: NUM_CH must be at least 1");
   end
   if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("txq_scheduler: DEPTH must be a power of two");
   end
   if (RETRY_LIMIT < 2) begin : g_bad_retry
      $error("txq_scheduler: RETRY_LIMIT must be at least 2");
   end
   if ((CMD_QUEUE < 0) || (CMD_QUEUE >= NUM_Q)) begin : g_bad_cmd
      $error("txq_scheduler: CMD_QUEUE out of range");
   end

   logic [NUM_Q-1:0]      q_ready;
   logic [PTR_W-1:0]      q_desc [NUM_Q];
   logic [NUM_Q-1:0]      q_grant;
   logic [NUM_Q-1:0]      q_cmp;
   logic [NUM_CH-1:0]     ch_any;
   logic [NUM_CH*Q_W-1:0] ch_sel;
   logic                  take;

   assign take = iss_valid && iss_ready;

   for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
      assign q_grant[q] = take && (iss_queue == Q_W'(q));
      assign q_cmp[q]   = cmp_valid && (cmp_queue == Q_W'(q));

      txq_queue_ctx #(
         .DEPTH        (DEPTH),
         .RETRY_LIMIT  (RETRY_LIMIT),
         .FORCE_STRICT (q == CMD_QUEUE)
      ) ctx_i (
         .clk          (clk),
         .rst_n        (rst_n),
         .cfg_active   (cfg_active[q]),
         .cfg_windowed (cfg_windowed[q]),
         .cfg_win      (cfg_win[q*WIN_W +: WIN_W]),
         .cfg_flim     (cfg_flim[q*WIN_W +: WIN_W]),
         .wr_ptr       (wr_ptr[q*PTR_W +: PTR_W]),
         .grant        (q_grant[q]),
         .cmp_hit      (q_cmp[q]),
         .cmp_ack      (cmp_ack),
         .ready        (q_ready[q]),
         .desc         (q_desc[q]),
         .rd_ptr       (rd_ptr[q*PTR_W +: PTR_W])
      );
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      logic [NUM_Q-1:0] req;

      always_comb begin
         for (int q = 0; q < NUM_Q; q++) begin
            req[q] = q_ready[q] && (cfg_chan[q*CH_W +: CH_W] == CH_W'(c));
         end
      end

      txq_chan_rr #(
         .NUM_Q   (NUM_Q)
      ) rr_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .req     (req),
         .advance (take && (iss_chan == CH_W'(c))),
         .any     (ch_any[c]),
         .sel     (ch_sel[c*Q_W +: Q_W])
      );
   end

   txq_chan_prio #(
      .NUM_Q  (NUM_Q),
      .NUM_CH (NUM_CH)
   ) prio_i (
      .ch_any (ch_any),
      .ch_sel (ch_sel),
      .valid  (iss_valid),
      .chan   (iss_chan),
      .queue  (iss_queue)
   );

   always_comb begin
      iss_desc = '0;
      for (int q = 0; q < NUM_Q; q++) begin
         if (iss_queue == Q_W'(q)) begin
            iss_desc = q_desc[q];
         end
      end
   end

endmodule

// File: rtl/txq_scheduler_chk.sv
module txq_scheduler_chk
   import txq_sched_pkg::*;
#(
   parameter int NUM_Q     = 16,
   parameter int NUM_CH    = 7,
   parameter int DEPTH     = 256,
   parameter int CMD_QUEUE = 4,
   localparam int Q_W      = $clog2(NUM_Q),
   localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH + 1) : 1,
   localparam int PTR_W    = $clog2(DEPTH),
   localparam int CW       = (PTR_W > WIN_W) ? PTR_W : WIN_W
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NUM_Q-1:0]       cfg_active,
   input logic [NUM_Q-1:0]       cfg_windowed,
   input logic [NUM_Q*CH_W-1:0]  cfg_chan,
   input logic [NUM_Q*WIN_W-1:0] cfg_win,
   input logic [NUM_Q*WIN_W-1:0] cfg_flim,
   input logic [NUM_Q*PTR_W-1:0] wr_ptr,
   input logic                   iss_valid,
   input logic [Q_W-1:0]         iss_queue,
   input logic [CH_W-1:0]        iss_chan,
   input logic [PTR_W-1:0]       iss_desc,
   input logic [NUM_Q*PTR_W-1:0] rd_ptr
);

   logic [CH_W-1:0]  s_chan;
   logic             s_act;
   logic             s_strict;
   logic             s_cmd;
   logic [PTR_W-1:0] s_rd;
   logic [PTR_W-1:0] s_wr;
   logic [WIN_W-1:0] s_win;
   logic [WIN_W-1:0] s_flim;
   logic [PTR_W-1:0] s_out;

   always_comb begin
      int i;
      i        = int'(iss_queue);
      s_chan   = cfg_chan[i*CH_W +: CH_W];
      s_act    = cfg_active[i];
      s_cmd    = (i == CMD_QUEUE);
      s_strict = !cfg_windowed[i] || s_cmd;
      s_rd     = rd_ptr[i*PTR_W +: PTR_W];
      s_wr     = wr_ptr[i*PTR_W +: PTR_W];
      s_win    = cfg_win[i*WIN_W +: WIN_W];
      s_flim   = cfg_flim[i*WIN_W +: WIN_W];
      s_out    = iss_desc - s_rd;
   end

   AST_CHAN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> (s_chan == iss_chan)); // R12

   AST_ACTIVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> s_act); // R2

   AST_NOT_AT_WR: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> (iss_desc != s_wr)); // R2

   AST_STRICT_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && s_strict) |-> (iss_desc == s_rd)); // R3

   AST_CMD_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && s_cmd) |-> (iss_desc == s_rd)); // R10

   AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && !s_strict) |-> ((CW'(s_out) < CW'(s_win)) && (CW'(s_out) < CW'(s_flim)))); // R5

   for (genvar q = 0; q < NUM_Q; q++) begin : g_rd
      AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_ptr[q*PTR_W +: PTR_W] != $past(rd_ptr[q*PTR_W +: PTR_W])) |->
         (rd_ptr[q*PTR_W +: PTR_W] == $past(rd_ptr[q*PTR_W +: PTR_W]) + PTR_W'(1))); // R3
   end

endmodule

bind txq_scheduler txq_scheduler_chk #(
   .NUM_Q     (NUM_Q),
   .NUM_CH    (NUM_CH),
   .DEPTH     (DEPTH),
   .CMD_QUEUE (CMD_QUEUE)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_active   (cfg_active),
   .cfg_windowed (cfg_windowed),
   .cfg_chan     (cfg_chan),
   .cfg_win      (cfg_win),
   .cfg_flim     (cfg_flim),
   .wr_ptr       (wr_ptr),
   .iss_valid    (iss_valid),
   .iss_queue    (iss_queue),
   .iss_chan     (iss_chan),
   .iss_desc     (iss_desc),
   .rd_ptr       (rd_ptr)
);

// File: tb/txq_scheduler_tb_top.sv
`timescale 1ns/1ps
module txq_scheduler_tb_top;

   localparam int NQ    = 16;
   localparam int NCH   = 7;
   localparam int DEP   = 256;
   localparam int RLIM  = 4;
   localparam int CMDQ  = 4;
   localparam int QW    = 4;
   localparam int CHW   = 3;
   localparam int PW    = 8;
   localparam int WW    = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   int c_act [NQ];
   int c_winm[NQ];
   int c_chan[NQ];
   int c_wsz [NQ];
   int c_flim[NQ];
   int c_wr  [NQ];

   logic [NQ-1:0]    cfg_active;
   logic [NQ-1:0]    cfg_windowed;
   logic [NQ*CHW-1:0] cfg_chan;
   logic [NQ*WW-1:0] cfg_win;
   logic [NQ*WW-1:0] cfg_flim;
   logic [NQ*PW-1:0] wr_ptr;
   logic             iss_valid;
   logic             iss_ready;
   logic [QW-1:0]    iss_queue;
   logic [CHW-1:0]   iss_chan;
   logic [PW-1:0]    iss_desc;
   logic             cmp_valid;
   logic [QW-1:0]    cmp_queue;
   logic             cmp_ack;
   logic [NQ*PW-1:0] rd_ptr;

   always_comb begin
      for (int q = 0; q < NQ; q++) begin
         cfg_active[q]            = (c_act[q] != 0);
         cfg_windowed[q]          = (c_winm[q] != 0);
         cfg_chan[q*CHW +: CHW]   = CHW'(c_chan[q]);
         cfg_win[q*WW +: WW]      = WW'(c_wsz[q]);
         cfg_flim[q*WW +: WW]     = WW'(c_flim[q]);
         wr_ptr[q*PW +: PW]       = PW'(c_wr[q]);
      end
   end

   txq_scheduler dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_active   (cfg_active),
      .cfg_windowed (cfg_windowed),
      .cfg_chan     (cfg_chan),
      .cfg_win      (cfg_win),
      .cfg_flim     (cfg_flim),
      .wr_ptr       (wr_ptr),
      .iss_valid    (iss_valid),
      .iss_ready    (iss_ready),
      .iss_queue    (iss_queue),
      .iss_chan     (iss_chan),
      .iss_desc     (iss_desc),
      .cmp_valid    (cmp_valid),
      .cmp_queue    (cmp_queue),
      .cmp_ack      (cmp_ack),
      .rd_ptr       (rd_ptr)
   );

   // behavioural model state
   int m_rd  [NQ];
   int m_snd [NQ];
   int m_busy[NQ];
   int m_try [NQ];
   int m_last[NCH];

   int    n_checks = 0;
   int    n_fails  = 0;
   string cur_req  = "R1";

   function automatic bit is_strict(int q);
      return (c_winm[q] == 0) || (q == CMDQ);
   endfunction

   function automatic int inflight(int q);
      return (m_snd[q] - m_rd[q] + DEP) % DEP;
   endfunction

   function automatic bit q_ready(int q);
      if (c_act[q] == 0) return 1'b0;
      if (is_strict(q)) return (m_busy[q] == 0) && (m_rd[q] != c_wr[q]);
      return (m_snd[q] != c_wr[q]) && (inflight(q) < c_wsz[q]) && (inflight(q) < c_flim[q]);
   endfunction

   function automatic void predict(output bit v, output int pq, output int pc, output int pd);
      v = 1'b0; pq = 0; pc = 0; pd = 0;
      for (int c = NCH - 1; c >= 0; c--) begin
         if (!v) begin
            for (int off = 1; off <= NQ; off++) begin
               int q;
               q = (m_last[c] + off) % NQ;
               if (!v && (c_chan[q] == c) && q_ready(q)) begin
                  v  = 1'b1;
                  pq = q;
                  pc = c;
                  pd = is_strict(q) ? m_rd[q] : m_snd[q];
               end
            end
         end
      end
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int q = 0; q < NQ; q++) begin
            m_rd[q] = 0; m_snd[q] = 0; m_busy[q] = 0; m_try[q] = 0;
         end
         for (int c = 0; c < NCH; c++) m_last[c] = NQ - 1;
      end else begin
         bit v; int pq; int pc; int pd; bit g;
         predict(v, pq, pc, pd);
         g = v && iss_ready;
         if (g) m_last[pc] = pq;
         for (int q = 0; q < NQ; q++) begin
            bit gq; bit cq;
            gq = g && (pq == q);
            cq = cmp_valid && (int'(cmp_queue) == q);
            if (is_strict(q)) begin
               if (cq && m_busy[q] != 0) begin
                  m_busy[q] = 0;
                  if (cmp_ack || m_try[q] == RLIM - 1) begin
                     m_rd[q] = (m_rd[q] + 1) % DEP;
                     m_try[q] = 0;
                  end else begin
                     m_try[q] = m_try[q] + 1;
                  end
               end else if (gq) begin
                  m_busy[q] = 1;
               end
               m_snd[q] = m_rd[q];
            end else begin
               m_busy[q] = 0; m_try[q] = 0;
               if (cq && inflight(q) != 0) begin
                  if (cmp_ack) begin
                     m_rd[q] = (m_rd[q] + 1) % DEP;
                     if (gq) m_snd[q] = (m_snd[q] + 1) % DEP;
                  end else begin
                     m_snd[q] = m_rd[q];
                  end
               end else if (gq) begin
                  m_snd[q] = (m_snd[q] + 1) % DEP;
               end
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         bit v; int pq; int pc; int pd;
         predict(v, pq, pc, pd);
         n_checks++;
         if (iss_valid !== v) begin
            n_fails++;
            $display("FAIL %s iss_valid actual %0b expected %0b", cur_req, iss_valid, v);
         end
         if (v) begin
            n_checks++;
            if (int'(iss_queue) != pq || int'(iss_chan) != pc || int'(iss_desc) != pd) begin
               n_fails++;
               $display("FAIL %s offer actual q%0d c%0d d%0d expected q%0d c%0d d%0d",
                        cur_req, iss_queue, iss_chan, iss_desc, pq, pc, pd);
            end
         end
         for (int q = 0; q < NQ; q++) begin
            n_checks++;
            if (int'(rd_ptr[q*PW +: PW]) != m_rd[q]) begin
               n_fails++;
               $display("FAIL %s rd_ptr[%0d] actual %0d expected %0d",
                        cur_req, q, rd_ptr[q*PW +: PW], m_rd[q]);
            end
         end
      end
   end

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic complete(int q, bit ack);
      cmp_valid = 1'b1;
      cmp_queue = QW'(q);
      cmp_ack   = ack;
      step(1);
      cmp_valid = 1'b0;
   endtask

   task automatic setq(int q, int act, int winm, int ch, int wsz, int fl, int wr);
      c_act[q] = act; c_winm[q] = winm; c_chan[q] = ch;
      c_wsz[q] = wsz; c_flim[q] = fl; c_wr[q] = wr;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog expired during %s", cur_req);
      finish_run();
   end

   initial begin
      for (int q = 0; q < NQ; q++) setq(q, 0, 0, 0, 0, 0, 0);
      iss_ready = 1'b1;
      cmp_valid = 1'b0;
      cmp_queue = '0;
      cmp_ack   = 1'b0;
      step(4);
      rst_n = 1'b1;
      cur_req = "R1";
      step(3);

      // R3: strict queue waits for each completion
      cur_req = "R3";
      setq(1, 1, 0, 1, 0, 0, 3);
      step(4);
      complete(1, 1'b1);
      step(2);
      complete(1, 1'b1);
      step(2);

      // R4: retry until the limit retires the descriptor
      cur_req = "R4";
      for (int k = 0; k < RLIM; k++) begin
         complete(1, 1'b0);
         step(2);
      end
      step(2);

      // R5: windowed queue bounded by window and frame limit
      cur_req = "R5";
      setq(1, 0, 0, 1, 0, 0, 3);
      setq(2, 1, 1, 2, 3, 5, 10);
      step(5);
      complete(2, 1'b1);
      step(3);
      c_flim[2] = 2;
      complete(2, 1'b1);
      step(3);
      complete(2, 1'b1);
      step(3);

      // R6: negative completion rewinds to the oldest descriptor
      cur_req = "R6";
      complete(2, 1'b0);
      step(4);
      c_wsz[2] = 20; c_flim[2] = 20;
      step(2);
      complete(2, 1'b0);
      step(3);
      c_act[2] = 0;
      step(1);

      // R7: round-robin among queues sharing channel 0
      cur_req = "R7";
      setq(5, 1, 1, 0, 10, 10, 3);
      setq(6, 1, 1, 0, 10, 10, 3);
      setq(7, 1, 1, 0, 10, 10, 3);
      step(12);
      setq(5, 0, 1, 0, 10, 10, 3);
      setq(6, 0, 1, 0, 10, 10, 3);
      setq(7, 0, 1, 0, 10, 10, 3);

      // R8: highest channel wins
      cur_req = "R8";
      setq(8, 1, 1, 0, 5, 5, 2);
      setq(9, 1, 1, 2, 5, 5, 2);
      setq(10, 1, 1, 3, 5, 5, 2);
      step(8);

      // R9: no acceptance while iss_ready is low
      cur_req = "R9";
      iss_ready = 1'b0;
      setq(11, 1, 1, 1, 8, 8, 4);
      step(5);
      iss_ready = 1'b1;
      step(6);

      // R2: disabled queue and out-of-range channel never issue
      cur_req = "R2";
      setq(12, 0, 1, 1, 8, 8, 5);
      setq(13, 1, 1, 7, 8, 8, 5);
      step(5);

      // R10: control queue stays strict with its mode bit set
      cur_req = "R10";
      setq(CMDQ, 1, 1, 3, 10, 10, 4);
      step(4);
      complete(CMDQ, 1'b1);
      step(3);
      complete(CMDQ, 1'b0);
      step(3);

      // R11: stray completions are ignored
      cur_req = "R11";
      complete(0, 1'b1);
      complete(3, 1'b0);
      complete(12, 1'b1);
      step(2);

      // R12 and modulo wrap of the read pointer
      cur_req = "R12";
      for (int q = 0; q < NQ; q++) c_act[q] = 0;
      setq(14, 1, 1, 6, 100, 100, 6);
      step(2);
      cur_req = "R5";
      for (int k = 0; k < 300; k++) begin
         c_wr[14]  = (m_rd[14] + 6) % DEP;
         cmp_valid = 1'b1;
         cmp_queue = QW'(14);
         cmp_ack   = 1'b1;
         step(1);
      end
      cmp_valid = 1'b0;
      step(3);

      finish_run();
   end

endmodule